// File: doc/BRIEF.md
# Software-Refilled Page Translation Cache

This block is a small, fully associative store of virtual-to-physical page translations placed ahead of the memory system. A requester presents a virtual page number with an access kind: load, store or instruction fetch. In the same cycle the block answers with a hit indication, the physical page number, the stored dirty flag, and one of two trap signals. The block never reads page tables itself. When no entry matches it raises a miss trap, and trap software then installs the translation through a write port.

Each slot holds a virtual page number, a physical page number, a three-bit permission field, and valid, dirty and reference flags. The reference flag drives a clock-style victim choice. An empty slot is always used first. When every slot is full, a rotating hand skips and clears referenced slots until it reaches an unreferenced one. A store that hits and is permitted marks the slot dirty, so that software can later decide whether the page must be written back. A single invalidate-all pulse empties the whole table. The slot that the next refill will use is visible on a port, so software and tests can observe the victim choice.

Top module: `soft_tlb`

## Requirements
- R1: After synchronous reset every slot is empty. Every lookup then misses, and `next_slot` reads 0.
- R2: A lookup hits when a valid slot holds the same virtual page number. `lk_hit` and `lk_ppn` then reflect that slot in the same cycle. `lk_ppn` reads 0 when there is no hit.
- R3: `miss_trap` is high exactly when `lk_valid` is high and no valid slot matches. No trap and no hit is reported while `lk_valid` is low.
- R4: The permission field uses bit 0 for read (access code 2'b00, load), bit 1 for write (2'b01, store) and bit 2 for execute (2'b10, fetch). A match whose access is not permitted raises `prot_trap` with `lk_hit` high and `miss_trap` low.
- R5: `lk_dirty` shows the stored dirty flag of the hit slot before any update. A permitted store hit sets the flag, and the next lookup shows it. A refused store leaves the flag clear.
- R6: A refill installs a valid entry in slot `next_slot`, with the dirty flag clear and the reference flag set. A lookup in the following cycle hits it.
- R7: While any slot is empty, `next_slot` is the lowest-numbered empty slot.
- R8: When all slots are valid, the victim is the first slot with a clear reference flag, scanning upward from the hand with wrap-around. A refill clears the reference flags of the slots it passes. If every flag is set, the victim is the hand slot and all flags are cleared. After such a refill the hand moves to victim+1.
- R9: Any lookup hit, permitted or not, sets the reference flag of the matched slot.
- R10: Refilling a virtual page number that is already present overwrites that slot in place. No other slot changes, and the hand does not move.
- R11: `inv_all` empties every slot in one cycle and takes priority over a refill in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lk_hit | output | 1 | A valid slot matched |
| lk_ppn | output | 20 | Physical page number of the matched slot |
| lk_dirty | output | 1 | Stored dirty flag of the matched slot |
| miss_trap | output | 1 | Lookup found no translation |
| prot_trap | output | 1 | Matched slot forbids this access |
| wr_en | input | 1 | Refill strobe |
| wr_vpn | input | 20 | Virtual page number to install |
| wr_ppn | input | 20 | Physical page number to install |
| wr_rights | input | 3 | Permission field to install |
| inv_all | input | 1 | Empty every slot |
| next_slot | output | 4 | Slot the next new refill will replace |

## Verification
A corrupted valid or tag field shows up as a wrong hit or miss on the very next lookup of that page. A lost or misplaced dirty flag becomes visible on `lk_dirty` when the page is next read. Reference-flag or hand errors do not touch lookups at all. They appear only on `next_slot`, and only once the table is full, so the stimulus deliberately fills every slot, drives the hand across referenced slots, and reads `next_slot` after each refill and after lookups that change the reference flags.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VPN_W       = 20;
    localparam int PPN_W       = 20;
    localparam int RIGHTS_W    = 3;
    localparam int ENTRIES_DEF = 16;

    localparam int RB_READ  = 0;
    localparam int RB_WRITE = 1;
    localparam int RB_EXEC  = 2;

    typedef logic [VPN_W-1:0]    vpn_t;
    typedef logic [PPN_W-1:0]    ppn_t;
    typedef logic [RIGHTS_W-1:0] rights_t;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef struct packed {
        logic    valid;
        logic    dirty;
        logic    refd;
        rights_t rights;
        vpn_t    vpn;
        ppn_t    ppn;
    } tlb_entry_t;

    function automatic logic rights_allow(input rights_t r, input logic [1:0] acc);
        case (acc)
            ACC_LOAD:  return r[RB_READ];
            ACC_STORE: return r[RB_WRITE];
            ACC_FETCH: return r[RB_EXEC];
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N = ENTRIES_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  tlb_entry_t ents [N],
    input  vpn_t       key,
    output logic [N-1:0] hits
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hits[g] = ents[g].valid && (ents[g].vpn == key);
    end

    // R10: in-place overwrite keeps every page present at most once
    p_single_match_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hits));

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     valid_vec,
    input  logic [N-1:0]     ref_vec,
    input  logic             advance,
    output logic [IDX_W-1:0] next_slot,
    output logic [N-1:0]     clear_mask
);

    logic [IDX_W-1:0] hand;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] scan_idx;
    logic [N-1:0]     passed;
    logic             any_free;

    assign any_free = ~&valid_vec;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) free_idx = IDX_W'(i);
        end
    end

    always_comb begin
        logic             found;
        logic [IDX_W-1:0] pos;
        found    = 1'b0;
        passed   = '0;
        scan_idx = hand;
        for (int k = 0; k < N; k++) begin
            pos = IDX_W'((int'(hand) + k) % N);
            if (!found) begin
                if (!ref_vec[pos]) begin
                    found    = 1'b1;
                    scan_idx = pos;
                end else begin
                    passed[pos] = 1'b1;
                end
            end
        end
        if (!found) begin
            scan_idx = hand;
            passed   = '1;
        end
    end

    assign next_slot  = any_free ? free_idx : scan_idx;
    assign clear_mask = any_free ? '0 : passed;

    always_ff @(posedge clk) begin
        if (rst) begin
            hand <= '0;
        end else if (advance && !any_free) begin
            hand <= IDX_W'((int'(scan_idx) + 1) % N);
        end
    end

    // R7: an empty slot is chosen while one exists
    p_free_first_r7: assert property (@(posedge clk) disable iff (rst)
        (!(&valid_vec)) |-> !valid_vec[next_slot]);

    // R8: a full table picks an unreferenced slot unless all are referenced
    p_clock_pick_r8: assert property (@(posedge clk) disable iff (rst)
        ((&valid_vec) && !(&ref_vec)) |-> !ref_vec[next_slot]);

endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = ENTRIES_DEF,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lk_valid,
    input  logic [VPN_W-1:0]    lk_vpn,
    input  logic [1:0]          lk_acc,
    output logic                lk_hit,
    output logic [PPN_W-1:0]    lk_ppn,
    output logic                lk_dirty,
    output logic                miss_trap,
    output logic                prot_trap,
    input  logic                wr_en,
    input  logic [VPN_W-1:0]    wr_vpn,
    input  logic [PPN_W-1:0]    wr_ppn,
    input  logic [RIGHTS_W-1:0] wr_rights,
    input  logic                inv_all,
    output logic [IDX_W-1:0]    next_slot
);

    tlb_entry_t ents [NUM_ENTRIES];

    logic [NUM_ENTRIES-1:0] lk_mv, wr_mv, valid_vec, ref_vec, clr_mask;
    logic [IDX_W-1:0]       hit_idx, dup_idx, wr_slot;
    logic                   any_match, allowed, st_ok, dup, advance;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_flags
        assign valid_vec[g] = ents[g].valid;
        assign ref_vec[g]   = ents[g].refd;
    end

    tlb_match #(.N(NUM_ENTRIES)) u_lk_match (
        .clk(clk), .rst(rst), .ents(ents), .key(lk_vpn), .hits(lk_mv)
    );

    tlb_match #(.N(NUM_ENTRIES)) u_wr_match (
        .clk(clk), .rst(rst), .ents(ents), .key(wr_vpn), .hits(wr_mv)
    );

    tlb_victim #(.N(NUM_ENTRIES)) u_victim (
        .clk(clk), .rst(rst), .valid_vec(valid_vec), .ref_vec(ref_vec),
        .advance(advance), .next_slot(next_slot), .clear_mask(clr_mask)
    );

    always_comb begin
        hit_idx = '0;
        dup_idx = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (lk_mv[i]) hit_idx = IDX_W'(i);
            if (wr_mv[i]) dup_idx = IDX_W'(i);
        end
    end

    assign any_match = |lk_mv;
    assign lk_hit    = lk_valid && any_match;
    assign lk_ppn    = lk_hit ? ents[hit_idx].ppn : '0;
    assign lk_dirty  = lk_hit && ents[hit_idx].dirty;
    assign allowed   = rights_allow(ents[hit_idx].rights, lk_acc);
    assign miss_trap = lk_valid && !any_match;
    assign prot_trap = lk_hit && !allowed;
    assign st_ok     = lk_hit && allowed && (lk_acc == ACC_STORE);

    assign dup     = |wr_mv;
    assign wr_slot = dup ? dup_idx : next_slot;
    assign advance = wr_en && !inv_all && !dup;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENTRIES; i++) ents[i] <= '0;
        end else if (inv_all) begin
            for (int i = 0; i < NUM_ENTRIES; i++) ents[i].valid <= 1'b0;
        end else begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (wr_en && wr_slot == IDX_W'(i)) begin
                    ents[i] <= '{valid: 1'b1, dirty: 1'b0, refd: 1'b1,
                                 rights: wr_rights, vpn: wr_vpn, ppn: wr_ppn};
                end else begin
                    if (advance && clr_mask[i])           ents[i].refd  <= 1'b0;
                    if (lk_hit && hit_idx == IDX_W'(i))   ents[i].refd  <= 1'b1;
                    if (st_ok && hit_idx == IDX_W'(i))    ents[i].dirty <= 1'b1;
                end
            end
        end
    end

    // R3/R4: the two traps never fire together and a miss is never a hit
    p_trap_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(miss_trap && prot_trap));
    p_miss_nohit_r3: assert property (@(posedge clk) disable iff (rst)
        miss_trap |-> !lk_hit);

    // R5: a permitted store leaves its slot dirty
    p_dirty_set_r5: assert property (@(posedge clk) disable iff (rst)
        (st_ok && !inv_all && !wr_en) |=> ents[$past(hit_idx)].dirty);

    // R6: an installed page is present in the slot written
    p_refill_seen_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !inv_all) |=> (ents[$past(wr_slot)].valid &&
                                 ents[$past(wr_slot)].vpn == $past(wr_vpn)));

    // R11: the table is empty the cycle after a flush
    p_flush_empty_r11: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> (valid_vec == '0));

endmodule

// File: tb/tb_soft_tlb.sv
module tb_soft_tlb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [1:0]  lk_acc = '0;
    logic        lk_hit, lk_dirty, miss_trap, prot_trap;
    logic [19:0] lk_ppn;
    logic        wr_en = 1'b0;
    logic [19:0] wr_vpn = '0;
    logic [19:0] wr_ppn = '0;
    logic [2:0]  wr_rights = '0;
    logic        inv_all = 1'b0;
    logic [3:0]  next_slot;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [23:0] exp_q [$];
    string       tag_q [$];

    soft_tlb dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_acc(lk_acc),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_dirty(lk_dirty), .miss_trap(miss_trap),
        .prot_trap(prot_trap), .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
        .wr_rights(wr_rights), .inv_all(inv_all), .next_slot(next_slot)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [23:0] act,
                         input logic [23:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: {hit, miss, prot, dirty, ppn}
    always @(negedge clk) begin
        if (lk_valid && exp_q.size() > 0) begin
            logic [23:0] e;
            logic [23:0] a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {lk_hit, miss_trap, prot_trap, lk_dirty, lk_ppn};
            check(a === e, t, a, e);
        end
    end

    task automatic lookup(input logic [19:0] vpn, input logic [1:0] acc,
                          input bit h, input bit m, input bit p, input bit d,
                          input logic [19:0] ppn, input string tag);
        @(posedge clk); #1;
        lk_vpn = vpn; lk_acc = acc;
        exp_q.push_back({h, m, p, d, ppn});
        tag_q.push_back(tag);
        lk_valid = 1'b1;
        @(posedge clk); #1;
        lk_valid = 1'b0;
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn,
                          input logic [2:0] r, input bit flush);
        @(posedge clk); #1;
        wr_vpn = vpn; wr_ppn = ppn; wr_rights = r; wr_en = 1'b1; inv_all = flush;
        @(posedge clk); #1;
        wr_en = 1'b0; inv_all = 1'b0;
    endtask

    task automatic slot_is(input logic [3:0] s, input string tag);
        @(negedge clk);
        check(next_slot === s, tag, {20'h0, next_slot}, {20'h0, s});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R3: idle port reports nothing
        @(negedge clk);
        check({lk_hit, miss_trap, prot_trap} === 3'b000, "R3 idle",
              {21'h0, lk_hit, miss_trap, prot_trap}, 24'h0);
        slot_is(4'd0, "R1 reset slot");
        lookup(20'h123, 2'd0, 0, 1, 0, 0, 20'h0, "R1 reset miss");

        // R7: fill in ascending empty order
        for (int i = 0; i < 16; i++) begin
            slot_is(4'(i), "R7 free slot");
            refill(20'h100 + 20'(i), 20'h500 + 20'(i),
                   (i == 3) ? 3'b001 : (i == 4) ? 3'b100 : 3'b011, 1'b0);
        end
        lookup(20'h105, 2'd0, 1, 0, 0, 0, 20'h505, "R2 hit");
        lookup(20'h10F, 2'd0, 1, 0, 0, 0, 20'h50F, "R2 hit last");
        lookup(20'h105, 2'd1, 1, 0, 0, 0, 20'h505, "R5 store old dirty");
        lookup(20'h105, 2'd0, 1, 0, 0, 1, 20'h505, "R5 dirty set");
        lookup(20'h103, 2'd1, 1, 0, 1, 0, 20'h503, "R4 write refused");
        lookup(20'h103, 2'd0, 1, 0, 0, 0, 20'h503, "R5 refused store clean");
        lookup(20'h104, 2'd2, 1, 0, 0, 0, 20'h504, "R4 fetch allowed");
        lookup(20'h104, 2'd0, 1, 0, 1, 0, 20'h504, "R4 read refused");
        lookup(20'h999, 2'd0, 0, 1, 0, 0, 20'h0,   "R3 miss");
        slot_is(4'd0, "R8 all referenced");

        // R10: duplicate overwrite
        refill(20'h107, 20'h777, 3'b011, 1'b0);
        lookup(20'h107, 2'd0, 1, 0, 0, 0, 20'h777, "R10 overwrite");
        lookup(20'h100, 2'd0, 1, 0, 0, 0, 20'h500, "R10 no eviction");
        slot_is(4'd0, "R10 hand kept");

        // R8: clock replacement
        refill(20'h200, 20'h600, 3'b011, 1'b0);
        lookup(20'h100, 2'd0, 0, 1, 0, 0, 20'h0,   "R8 victim evicted");
        lookup(20'h200, 2'd0, 1, 0, 0, 0, 20'h600, "R6 installed");
        slot_is(4'd1, "R8 hand advanced");
        lookup(20'h101, 2'd0, 1, 0, 0, 0, 20'h501, "R9 hit");
        lookup(20'h102, 2'd0, 1, 0, 0, 0, 20'h502, "R9 hit");
        slot_is(4'd3, "R9 ref skipped");
        refill(20'h201, 20'h601, 3'b011, 1'b0);
        lookup(20'h103, 2'd0, 0, 1, 0, 0, 20'h0,   "R8 victim evicted");
        lookup(20'h201, 2'd0, 1, 0, 0, 0, 20'h601, "R6 installed");
        slot_is(4'd4, "R8 hand past victim");

        // R11: flush beats same-cycle refill
        refill(20'h300, 20'h700, 3'b011, 1'b1);
        lookup(20'h200, 2'd0, 0, 1, 0, 0, 20'h0, "R11 flushed");
        lookup(20'h300, 2'd0, 0, 1, 0, 0, 20'h0, "R11 refill dropped");
        slot_is(4'd0, "R11 empty slot");
        refill(20'h400, 20'h401, 3'b111, 1'b0);
        lookup(20'h400, 2'd1, 1, 0, 0, 0, 20'h401, "R6 after flush");

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) check(1'b0, "scoreboard drain", 24'(exp_q.size()), 24'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule